// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory Transfer Engine

This block moves data between two memory locations, one unit per activation request. Software programs a read address, a write address, a unit count and two control words through a small register port, then starts the channel. Every rising edge on the chosen request line moves one unit: a read from the read address, then a write of that data to the write address. After each unit, both addresses can step up, step down or stay where they are, and the count goes down by one.

The channel runs only when three things hold together: a master enable, a channel enable, and the mode field set to the single-unit (normal) mode. Each enable bit is guarded against stray writes: software must read the register while the bit is 0 before a write of 1 takes effect. A non-maskable event input clears the master enable at once, so a channel that is being set up never starts. When the count runs out, the channel enable clears itself and a done flag is raised. An optional interrupt follows the flag. Both stay set until software writes 0 to the channel-enable bit.

Top module: `dmach_top`

## Requirements
- R1: After synchronous reset, all six registers read as 0, `mem_req` is 0 and `irq` is 0.
- R2: A write of 1 to an enable bit (CTLA bit 0 = channel enable, select 3; CTLB bit 0 = master enable, select 4) takes effect only if a read of that register, made while the bit was 0, came before it with no other write to that register in between. Otherwise the bit stays 0.
- R3: A transfer starts only when the master enable is 1, the channel enable is 1 and CTLA bits 6:4 equal 3'b110. Requests that arrive at any other time are dropped.
- R4: Each accepted request gives exactly one read at the read address (select 0), followed by one write of the data read to the write address (select 1). A transaction completes in a cycle where `mem_req` and `mem_ready` are both high, and until then its address and direction are held.
- R5: After each unit, the read address steps as set by CTLA bit 2 (step enable) and bit 3 (1 = down), and the write address steps as set by CTLB bit 1 (step enable) and bit 2 (1 = down). The step size is 1 for bytes and 2 for words.
- R6: CTLA bit 1 selects word size (1) or byte size (0). For a word, `mem_size` is 1 and `mem_addr` bit 0 is driven 0.
- R7: For a byte, the upper byte of `mem_wdata` is 0 and the lower byte is the lower byte that was read.
- R8: The count (select 2) goes down by one per unit. On the unit that brings it to 0, the channel enable clears and the done flag (select 5, bit 0) is set.
- R9: `irq` is high from the cycle after the done flag sets, provided CTLA bit 7 is 1. Writing CTLA with bit 0 = 0 clears the done flag, and `irq` falls one cycle later. With bit 7 = 0, `irq` stays low.
- R10: `nmi` high clears the master enable and its read guard. This overrides a write of the master enable in the same cycle, so no later request starts a transfer.
- R11: CTLB bits 5:3 select which `trig_in` line is the activation source. Only a rising edge on that line is a request, so a line held high moves one unit, and the other lines are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select: 0 read addr, 1 write addr, 2 count, 3 CTLA, 4 CTLB, 5 status |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data, valid the cycle after `reg_rd` |
| trig_in | input | TRIG_N | Activation request lines |
| nmi | input | 1 | Non-maskable event; clears master enable |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = word, 0 = byte |
| mem_addr | output | ADDR_W | Transaction address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Transaction completes this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ready` |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
A non-maskable event and a software write that sets the master enable can arrive on the same clock edge. The bench arms the guard with a read, then drives `reg_wr` to select 4 with bit 0 = 1 and `nmi` high in the same cycle. It judges the result by reading the master enable back as 0 and by seeing that a later request gives no bus traffic. The count reaching zero and the final write completing also land on one edge. This is judged by the count, status, enable and `irq` values read after each sweep configuration.

// File: rtl/dmach_pkg.sv
`timescale 1ns/1ps
package dmach_pkg;
  typedef enum logic [1:0] {XS_IDLE, XS_RD, XS_WR} xfer_st_t;

  localparam logic [2:0] MODE_NORMAL = 3'b110;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTLA = 3'd3;
  localparam logic [2:0] SEL_CTLB = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  // channel control word, bit 7 down to bit 0
  typedef struct packed {
    logic       irq_en;
    logic [2:0] mode;
    logic       src_dec;
    logic       src_step;
    logic       wsize;
    logic       chan_en;
  } ctla_t;

  // master control word, bit 5 down to bit 0
  typedef struct packed {
    logic [2:0] tsel;
    logic       dst_dec;
    logic       dst_step;
    logic       master_en;
  } ctlb_t;
endpackage

// File: rtl/dmach_addr_step.sv
`timescale 1ns/1ps
module dmach_addr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic          step_en,
  input  logic          dec,
  input  logic          wsize,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] delta;
  assign delta = wsize ? AW'(2) : AW'(1);

  always_comb begin
    if (!step_en)  nxt = cur;
    else if (dec)  nxt = cur - delta;
    else           nxt = cur + delta;
  end
endmodule

// File: rtl/dmach_regs.sv
`timescale 1ns/1ps
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          nmi,
  input  logic          unit_done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output ctla_t         ctla,
  output ctlb_t         ctlb,
  output logic          done_q
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;
  logic [AW-1:0] src_nxt, dst_nxt;
  logic          arm_a, arm_b;
  logic [RW-1:0] rnext;

  assign cnt_dec = cnt_q - CW'(1);

  dmach_addr_step #(.AW(AW)) i_src_step (
    .cur(src_q), .step_en(ctla.src_step), .dec(ctla.src_dec),
    .wsize(ctla.wsize), .nxt(src_nxt)
  );

  dmach_addr_step #(.AW(AW)) i_dst_step (
    .cur(dst_q), .step_en(ctlb.dst_step), .dec(ctlb.dst_dec),
    .wsize(ctla.wsize), .nxt(dst_nxt)
  );

  always_comb begin
    case (reg_sel)
      SEL_SRC:  rnext = RW'(src_q);
      SEL_DST:  rnext = RW'(dst_q);
      SEL_CNT:  rnext = RW'(cnt_q);
      SEL_CTLA: rnext = RW'(ctla);
      SEL_CTLB: rnext = RW'(ctlb);
      SEL_STAT: rnext = RW'(done_q);
      default:  rnext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      ctla      <= '0;
      ctlb      <= '0;
      done_q    <= 1'b0;
      arm_a     <= 1'b0;
      arm_b     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_rd) begin
        reg_rdata <= rnext;
        if (reg_sel == SEL_CTLA && !ctla.chan_en)   arm_a <= 1'b1;
        if (reg_sel == SEL_CTLB && !ctlb.master_en) arm_b <= 1'b1;
      end
      if (unit_done) begin
        src_q <= src_nxt;
        dst_q <= dst_nxt;
        cnt_q <= cnt_dec;
        if (cnt_dec == '0) begin
          ctla.chan_en <= 1'b0;
          done_q       <= 1'b1;
        end
      end
      if (reg_wr) begin
        case (reg_sel)
          SEL_SRC: src_q <= reg_wdata[AW-1:0];
          SEL_DST: dst_q <= reg_wdata[AW-1:0];
          SEL_CNT: cnt_q <= reg_wdata[CW-1:0];
          SEL_CTLA: begin
            ctla.irq_en   <= reg_wdata[7];
            ctla.mode     <= reg_wdata[6:4];
            ctla.src_dec  <= reg_wdata[3];
            ctla.src_step <= reg_wdata[2];
            ctla.wsize    <= reg_wdata[1];
            ctla.chan_en  <= reg_wdata[0] & (ctla.chan_en | arm_a);
            if (!reg_wdata[0]) done_q <= 1'b0;
            arm_a <= 1'b0;
          end
          SEL_CTLB: begin
            ctlb.tsel      <= reg_wdata[5:3];
            ctlb.dst_dec   <= reg_wdata[2];
            ctlb.dst_step  <= reg_wdata[1];
            ctlb.master_en <= reg_wdata[0] & (ctlb.master_en | arm_b);
            arm_b <= 1'b0;
          end
          default: ;
        endcase
      end
      if (nmi) begin
        ctlb.master_en <= 1'b0;
        arm_b          <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmach_xfer.sv
`timescale 1ns/1ps
module dmach_xfer
  import dmach_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_ok,
  input  logic          req_edge,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] dst_a,
  input  logic          wsize,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          unit_done
);
  localparam int BYTE_W = 8;

  xfer_st_t st;
  logic     pending;
  logic     start;

  assign start     = (st == XS_IDLE) && pending && run_ok;
  assign unit_done = (st == XS_WR) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (!run_ok) begin
      pending <= 1'b0;
    end else if (start) begin
      pending <= req_edge;
    end else if (req_edge) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= XS_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        XS_IDLE: if (start) begin
          st       <= XS_RD;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_a;
          mem_size <= wsize;
        end
        XS_RD: if (mem_ready) begin
          st        <= XS_WR;
          mem_we    <= 1'b1;
          mem_addr  <= dst_a;
          mem_wdata <= wsize ? mem_rdata
                             : {{(DW-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
        end
        XS_WR: if (mem_ready) begin
          st      <= XS_IDLE;
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmach_top.sv
`timescale 1ns/1ps
module dmach_top
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int REG_W  = 16,
  parameter int TRIG_N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [TRIG_N-1:0] trig_in,
  input  logic              nmi,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  localparam int SEL_LINES = 8;

  ctla_t             ctla;
  ctlb_t             ctlb;
  logic [ADDR_W-1:0] src_q, dst_q, src_a, dst_a;
  logic              done;
  logic              unit_done;
  logic              run_ok;
  logic              master_en, irq_en;
  logic [SEL_LINES-1:0] trig_pad, trig_prev;
  logic              req_edge;

  for (genvar i = 0; i < SEL_LINES; i++) begin : g_pad
    if (i < TRIG_N) begin : g_on
      assign trig_pad[i] = trig_in[i];
    end else begin : g_off
      assign trig_pad[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trig_prev <= '0;
    else     trig_prev <= trig_pad;
  end

  assign req_edge  = trig_pad[ctlb.tsel] & ~trig_prev[ctlb.tsel];
  assign master_en = ctlb.master_en;
  assign irq_en    = ctla.irq_en;
  assign run_ok    = master_en & ctla.chan_en & (ctla.mode == MODE_NORMAL);
  assign src_a     = ctla.wsize ? {src_q[ADDR_W-1:1], 1'b0} : src_q;
  assign dst_a     = ctla.wsize ? {dst_q[ADDR_W-1:1], 1'b0} : dst_q;

  dmach_regs #(.AW(ADDR_W), .CW(CNT_W), .RW(REG_W)) i_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi(nmi), .unit_done(unit_done), .src_q(src_q), .dst_q(dst_q),
    .ctla(ctla), .ctlb(ctlb), .done_q(done)
  );

  dmach_xfer #(.AW(ADDR_W), .DW(DATA_W)) i_xfer (
    .clk(clk), .rst(rst), .run_ok(run_ok), .req_edge(req_edge),
    .src_a(src_a), .dst_a(dst_a), .wsize(ctla.wsize),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .unit_done(unit_done)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= done & irq_en;
  end
endmodule

// File: rtl/dmach_checks.sv
`timescale 1ns/1ps
module dmach_checks #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          nmi,
  input logic          master_en,
  input logic          run_ok,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic          mem_size,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic          done,
  input logic          irq_en
);
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!mem_req && !irq));

  p_start_needs_enables_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(run_ok));

  p_read_then_write_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

  p_hold_until_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_word_even_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_size) |-> !mem_addr[0]);

  p_irq_follows_done_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done && irq_en));

  p_nmi_wins_r10: assert property (@(posedge clk) disable iff (rst)
    nmi |=> !master_en);
endmodule

bind dmach_top dmach_checks #(.AW(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .nmi(nmi), .master_en(master_en), .run_ok(run_ok),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_size(mem_size), .mem_addr(mem_addr), .irq(irq), .done(done),
  .irq_en(irq_en)
);

// File: tb/test_dmach_top.sv
`timescale 1ns/1ps
module test_dmach_top;
  localparam int AW = 16, DW = 16, RW = 16, TN = 8;
  localparam logic [2:0] S_SRC = 3'd0, S_DST = 3'd1, S_CNT = 3'd2,
                         S_CA = 3'd3, S_CB = 3'd4, S_ST = 3'd5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic [TN-1:0] trig_in = '0;
  logic          nmi = 1'b0;
  logic          mem_req, mem_we, mem_size;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          irq;

  always #2.5 clk = ~clk;

  dmach_top i_dmach_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in), .nmi(nmi),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  int vectors = 0, miscompares = 0;
  int lat = 0, wc = 0, nlog = 0;
  logic          log_we   [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (a * 16'd37) ^ 16'h5AC3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: decides ready away from the active edge
  always @(negedge clk) begin
    if (rst || !mem_req) begin
      mem_ready = 1'b0;
      wc = 0;
    end else if (wc >= lat) begin
      mem_ready = 1'b1;
      mem_rdata = pat(mem_addr);
      if (nlog < 64) begin
        log_we[nlog] = mem_we;
        log_addr[nlog] = mem_addr;
        log_data[nlog] = mem_wdata;
      end
      nlog++;
      wc = 0;
    end else begin
      mem_ready = 1'b0;
      wc++;
    end
  end

  task automatic wr(input logic [2:0] s, input logic [RW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [RW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_sel = s;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); trig_in[line] = 1'b1;
    @(negedge clk); trig_in[line] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    logic [RW-1:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(!mem_req, "R1 mem_req", 32'(mem_req), 0);
    chk(!irq, "R1 irq", 32'(irq), 0);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), d);
      chk(d == 0, "R1 register", 32'(d), 0);
    end

    // R2: enable needs prior read with bit clear
    wr(S_CA, 16'h0060);
    wr(S_CA, 16'h0061);
    rd(S_CA, d);
    chk(d[0] == 1'b0, "R2 chan enable without read", 32'(d), 32'h60);
    wr(S_CA, 16'h0061);
    rd(S_CA, d);
    chk(d == 16'h0061, "R2 chan enable after read", 32'(d), 32'h61);
    wr(S_CB, 16'h0000);
    wr(S_CB, 16'h0001);
    rd(S_CB, d);
    chk(d[0] == 1'b0, "R2 master enable without read", 32'(d), 0);

    // R3: master off, then wrong mode
    wr(S_SRC, 16'h0100); wr(S_DST, 16'h0200); wr(S_CNT, 16'd5);
    nlog = 0;
    pulse(0);
    chk(nlog == 0, "R3 master off blocks", 32'(nlog), 0);
    wr(S_CB, 16'h0001);
    rd(S_CB, d);
    chk(d[0] == 1'b1, "R2 master enable after read", 32'(d), 1);
    wr(S_CA, 16'h0051);
    pulse(0);
    chk(nlog == 0, "R3 mode 101 blocks", 32'(nlog), 0);
    wr(S_CA, 16'h0061);

    // R11: wrong line ignored, held line moves one unit
    pulse(3);
    chk(nlog == 0, "R11 other line ignored", 32'(nlog), 0);
    @(negedge clk); trig_in[0] = 1'b1;
    repeat (20) @(negedge clk);
    trig_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk(nlog == 2, "R11 held line one unit", 32'(nlog), 2);
    chk(log_addr[0] == 16'h0100 && log_addr[1] == 16'h0200, "R4 directed addrs",
        {log_addr[0], log_addr[1]}, 32'h01000200);

    // R10: nmi clears master; same-cycle write loses
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    rd(S_CB, d);
    chk(d[0] == 1'b0, "R10 nmi clears master", 32'(d), 0);
    nlog = 0;
    pulse(0);
    chk(nlog == 0, "R10 no transfer after nmi", 32'(nlog), 0);
    @(negedge clk); reg_wr = 1'b1; reg_sel = S_CB; reg_wdata = 16'h0001; nmi = 1'b1;
    @(negedge clk); reg_wr = 1'b0; nmi = 1'b0;
    rd(S_CB, d);
    chk(d[0] == 1'b0, "R10 nmi beats write", 32'(d), 0);
    pulse(0);
    chk(nlog == 0, "R10 still idle", 32'(nlog), 0);
    wr(S_CA, 16'h0060);

    // sweep: step modes x step modes x size x latency
    base = 0;
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int w = 0; w < 2; w++)
          for (int l = 0; l < 2; l++) begin
            logic [RW-1:0] ca, cb;
            logic [AW-1:0] s0, d0, ea, eb;
            logic [DW-1:0] ed;
            int sd, dd, line, ie;
            line = base % TN;
            ie = (ss + ds + w + l) % 2;
            s0 = 16'h1001 + AW'(base * 16);
            d0 = 16'h2000 + AW'(base * 32);
            sd = (ss == 0) ? 0 : ((ss == 1) ? 1 : -1) * (w ? 2 : 1);
            dd = (ds == 0) ? 0 : ((ds == 1) ? 1 : -1) * (w ? 2 : 1);
            ca = RW'(ie << 7) | 16'h0060 | RW'((ss == 2) << 3) |
                 RW'((ss != 0) << 2) | RW'(w << 1);
            cb = RW'(line << 3) | RW'((ds == 2) << 2) | RW'((ds != 0) << 1);
            lat = l;
            wr(S_SRC, s0); wr(S_DST, d0); wr(S_CNT, 16'd3);
            wr(S_CA, ca); rd(S_CA, d); wr(S_CA, ca | 16'h1);
            wr(S_CB, cb); rd(S_CB, d); wr(S_CB, cb | 16'h1);
            nlog = 0;
            for (int k = 0; k < 3; k++) pulse(line);
            chk(nlog == 6, "R4 six transactions", 32'(nlog), 6);
            for (int k = 0; k < 3 && nlog == 6; k++) begin
              ea = s0 + AW'(k * sd);
              eb = d0 + AW'(k * dd);
              if (w == 1) begin ea[0] = 1'b0; eb[0] = 1'b0; end
              ed = (w == 1) ? pat(ea) : {8'h00, pat(ea)[7:0]};
              chk(!log_we[2*k] && log_addr[2*k] == ea, "R5 read address",
                  32'(log_addr[2*k]), 32'(ea));
              chk(log_we[2*k+1] && log_addr[2*k+1] == eb, "R5 write address",
                  32'(log_addr[2*k+1]), 32'(eb));
              chk(log_data[2*k+1] == ed, w ? "R6 word data" : "R7 byte data",
                  32'(log_data[2*k+1]), 32'(ed));
            end
            rd(S_CNT, d);
            chk(d == 0, "R8 count exhausted", 32'(d), 0);
            rd(S_ST, d);
            chk(d == 1, "R8 done flag", 32'(d), 1);
            rd(S_CA, d);
            chk(d[0] == 1'b0, "R8 chan enable cleared", 32'(d), 32'(ca));
            chk(irq == ie[0], "R9 irq level", 32'(irq), 32'(ie));
            wr(S_CA, ca);
            @(negedge clk);
            chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);
            rd(S_ST, d);
            chk(d == 0, "R9 done cleared", 32'(d), 0);
            base++;
          end
    summary();
  end
endmodule